// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block recovers characters from an asynchronous serial line. It needs an oversample tick that runs at sixteen times the bit rate. A falling edge on the idle-high line is confirmed as a start bit at its midpoint. The character bits are sampled at their midpoints, least significant bit first. An optional parity bit follows, then one or two stop bits.

When a character is complete, it moves from the internal shift register into a one-entry receive buffer. At the same moment a one-cycle receive request pulse is raised. Framing and parity status are latched into sticky flags at that transfer.

The buffer is the output stream. `buf_valid` stays high while the buffer holds an unread character. A read takes place on any clock edge where `buf_valid` and `buf_ready` are both high. The serial line cannot be stalled, so the back-pressure rule is simple: if the consumer leaves the buffer unread too long, the next character is lost and an overrun is reported. Clearing follows fixed rules:
- A read clears the framing and parity flags.
- Dropping the receive enable, or selecting serial mode `000`, clears all three flags.
- The error-sum output is high exactly while any flag is set.

Top module: `serial_rx_core`

## Requirements
- R1: An overrun is judged at the sample of the bit just before the final stop bit. For one stop bit, this is the parity bit, or the last character bit when parity is off. For two stop bits, it is the first stop bit. If the buffer is unread at that sample, `ovr_err` sets. A read before that sample avoids the overrun.
- R2: A frame that overran is discarded. The buffer keeps its earlier contents, and `rx_irq` is not pulsed for that frame.
- R3: `frame_err` sets at transfer if any configured stop bit was sampled low.
- R4: With `par_en`=1, `par_err` sets at transfer when the count of ones over the character bits and the parity bit is odd while `par_odd`=0, or even while `par_odd`=1. The transmitted parity bit makes that count even when `par_odd`=0 and odd when `par_odd`=1.
- R5: `err_sum` is high while any of `ovr_err`, `frame_err` or `par_err` is high. It falls only once all three are low.
- R6: While `rx_en`=0 or `mode_sel`=3'b000, reception is halted and all three error flags clear on the next clock.
- R7: A read (`buf_valid` and `buf_ready` both high) clears `frame_err` and `par_err` and empties the buffer. It leaves `ovr_err` unchanged.
- R8: A low level that is no longer low at the eighth oversample tick after the falling edge is rejected as noise. No character results from it.
- R9: `char_len` selects the character length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 gives 9 bits, and 2'b11 gives 8 bits. Bits arrive LSB first and appear right-aligned on `buf_data`, with the unused upper bits zero.
- R10: Each accepted character raises `rx_irq` for exactly one clock. `buf_valid` rises at that same edge.
- R11: After reset, `buf_valid`, `rx_irq` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-clock strobe at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| mode_sel | input | 3 | Serial mode select; 3'b000 disables the receiver |
| rx_en | input | 1 | Receive enable |
| char_len | input | 2 | Character length code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| buf_ready | input | 1 | Consumer accepts the buffer |
| buf_valid | output | 1 | Buffer holds an unread character |
| buf_data | output | MAX_BITS | Received character |
| rx_irq | output | 1 | Receive-complete pulse |
| ovr_err | output | 1 | Overrun flag |
| frame_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| err_sum | output | 1 | Any error flag set |

## Verification
A wrong oversample count or bit index shows up within a single frame, as a shifted or truncated character on `buf_data`. A parity accumulator or stop-bit latch that is off shows as a wrong `par_err` or `frame_err` as soon as the next character transfers. If the overrun decision is made at the wrong bit, the results move across the read deadline. A read during the data bits must then avoid the overrun, and a read during the second stop bit must not avoid it; a wrong decision point breaks one of these two cases within one frame time. A clear rule on the wrong flag shows up on the clock after the read or disable.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic fe;
    logic pe;
  } frame_stat_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int MAX_BITS = 9,
  parameter int OS_RATE  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                os_tick,
  input  logic                rx,
  input  logic [1:0]          char_len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic                buf_full,
  output logic                ovr_hit,
  output logic                xfer,
  output logic [MAX_BITS-1:0] xfer_data,
  output frame_stat_t         xfer_stat
);
  localparam int CW  = $clog2(OS_RATE);
  localparam int IW  = $clog2(MAX_BITS);
  localparam int MID = OS_RATE / 2 - 1;

  rx_state_e           state;
  logic [CW-1:0]       cnt;
  logic [IW-1:0]       idx;
  logic [IW-1:0]       last_idx;
  logic [MAX_BITS-1:0] shreg;
  logic                rx_prev, par_acc, stop_bad, frame_ovr;
  logic                samp, prefinal;

  always_comb begin
    case (char_len)
      2'b00:   last_idx = IW'(6);
      2'b10:   last_idx = IW'(8);
      default: last_idx = IW'(7);
    endcase
  end

  assign samp = os_tick && (cnt == CW'(OS_RATE - 1));

  always_comb begin
    prefinal = 1'b0;
    if (samp) begin
      case (state)
        ST_DATA:  prefinal = (idx == last_idx) && !par_en && !two_stop;
        ST_PAR:   prefinal = !two_stop;
        ST_STOP1: prefinal = two_stop;
        default:  prefinal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      rx_prev   <= 1'b1;
      par_acc   <= 1'b0;
      stop_bad  <= 1'b0;
      frame_ovr <= 1'b0;
      ovr_hit   <= 1'b0;
      xfer      <= 1'b0;
      xfer_data <= '0;
      xfer_stat <= '0;
    end else begin
      ovr_hit <= 1'b0;
      xfer    <= 1'b0;
      rx_prev <= rx;
      if (prefinal && buf_full) begin
        frame_ovr <= 1'b1;
        ovr_hit   <= 1'b1;
      end
      if (!enable) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (rx_prev && !rx) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (os_tick) begin
              if (cnt == CW'(MID)) begin
                cnt <= '0;
                if (!rx) begin
                  state     <= ST_DATA;
                  idx       <= '0;
                  shreg     <= '0;
                  par_acc   <= 1'b0;
                  stop_bad  <= 1'b0;
                  frame_ovr <= 1'b0;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: begin
            if (os_tick) cnt <= cnt + 1'b1;
            if (samp) begin
              cnt <= '0;
              case (state)
                ST_DATA: begin
                  shreg[idx] <= rx;
                  par_acc    <= par_acc ^ rx;
                  if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP1;
                  else                 idx   <= idx + 1'b1;
                end
                ST_PAR: begin
                  par_acc <= par_acc ^ rx;
                  state   <= ST_STOP1;
                end
                ST_STOP1: begin
                  if (two_stop) begin
                    stop_bad <= !rx;
                    state    <= ST_STOP2;
                  end else begin
                    state        <= ST_IDLE;
                    xfer         <= !frame_ovr && !(prefinal && buf_full);
                    xfer_data    <= shreg;
                    xfer_stat.fe <= !rx;
                    xfer_stat.pe <= par_en && (par_acc != par_odd);
                  end
                end
                default: begin
                  state        <= ST_IDLE;
                  xfer         <= !frame_ovr;
                  xfer_data    <= shreg;
                  xfer_stat.fe <= stop_bad || !rx;
                  xfer_stat.pe <= par_en && (par_acc != par_odd);
                end
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_rx_buffer.sv
module srx_rx_buffer
  import srx_pkg::*;
#(
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                ovr_hit,
  input  logic                xfer,
  input  logic [MAX_BITS-1:0] xfer_data,
  input  frame_stat_t         xfer_stat,
  input  logic                buf_ready,
  output logic                buf_valid,
  output logic [MAX_BITS-1:0] buf_data,
  output logic                rx_irq,
  output logic                ovr_err,
  output logic                frame_err,
  output logic                par_err
);
  logic take;
  assign take = buf_valid && buf_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
      rx_irq    <= 1'b0;
      ovr_err   <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (take) buf_valid <= 1'b0;
      if (!enable) begin
        ovr_err   <= 1'b0;
        frame_err <= 1'b0;
        par_err   <= 1'b0;
      end else begin
        if (take) begin
          frame_err <= 1'b0;
          par_err   <= 1'b0;
        end
        if (ovr_hit) ovr_err <= 1'b1;
        if (xfer) begin
          buf_data  <= xfer_data;
          buf_valid <= 1'b1;
          rx_irq    <= 1'b1;
          frame_err <= frame_err || xfer_stat.fe;
          par_err   <= par_err || xfer_stat.pe;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int MAX_BITS    = 9,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                os_tick,
  input  logic                rx_line,
  input  logic [2:0]          mode_sel,
  input  logic                rx_en,
  input  logic [1:0]          char_len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic                buf_ready,
  output logic                buf_valid,
  output logic [MAX_BITS-1:0] buf_data,
  output logic                rx_irq,
  output logic                ovr_err,
  output logic                frame_err,
  output logic                par_err,
  output logic                err_sum
);
  logic                enable, rx_s, ovr_hit, xfer;
  logic [MAX_BITS-1:0] xfer_data;
  frame_stat_t         xfer_stat;

  assign enable = rx_en && (mode_sel != 3'b000);

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
  );

  srx_frame_fsm #(.MAX_BITS(MAX_BITS), .OS_RATE(OS_RATE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .os_tick(os_tick), .rx(rx_s),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .buf_full(buf_valid), .ovr_hit(ovr_hit),
    .xfer(xfer), .xfer_data(xfer_data), .xfer_stat(xfer_stat)
  );

  srx_rx_buffer #(.MAX_BITS(MAX_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ovr_hit(ovr_hit),
    .xfer(xfer), .xfer_data(xfer_data), .xfer_stat(xfer_stat),
    .buf_ready(buf_ready), .buf_valid(buf_valid), .buf_data(buf_data),
    .rx_irq(rx_irq), .ovr_err(ovr_err), .frame_err(frame_err),
    .par_err(par_err)
  );

  assign err_sum = ovr_err || frame_err || par_err;
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic [2:0] mode_sel,
  input logic       buf_valid,
  input logic       buf_ready,
  input logic       rx_irq,
  input logic       ovr_err,
  input logic       frame_err,
  input logic       par_err,
  input logic       err_sum
);
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(buf_valid, 2));  // R1
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);  // R10
  AST_IRQ_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> buf_valid);  // R10
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || mode_sel == 3'b000) |=> (!ovr_err && !frame_err && !par_err));  // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && buf_ready) |=> (!frame_err && !par_err && !buf_valid));  // R7
  AST_SUM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_sum) |-> (!ovr_err && !frame_err && !par_err));  // R5
endmodule

bind serial_rx_core srx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_sel(mode_sel),
  .buf_valid(buf_valid), .buf_ready(buf_ready), .rx_irq(rx_irq),
  .ovr_err(ovr_err), .frame_err(frame_err), .par_err(par_err),
  .err_sum(err_sum)
);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [2:0] mode_sel = 3'b001;
  logic       rx_en = 1'b1;
  logic [1:0] char_len = 2'b01;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       buf_ready = 1'b0;
  logic       buf_valid, rx_irq, ovr_err, frame_err, par_err, err_sum;
  logic [8:0] buf_data;

  int n_chk = 0, n_bad = 0, irq_cnt = 0, div = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    div     = (div + 1) % 4;
    os_tick = (div == 0);
    if (rx_irq) irq_cnt++;
  end

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .mode_sel(mode_sel), .rx_en(rx_en), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .buf_ready(buf_ready), .buf_valid(buf_valid), .buf_data(buf_data),
    .rx_irq(rx_irq), .ovr_err(ovr_err), .frame_err(frame_err),
    .par_err(par_err), .err_sum(err_sum)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] code);
    return (code == 2'b00) ? 7 : (code == 2'b10) ? 9 : 8;
  endfunction

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // bad_par flips the parity bit; bad_stop 1/2 drives that stop bit low
  task automatic send(input int data, input bit bad_par, input int bad_stop);
    int n = len_of(char_len);
    int ones = 0;
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      hold_bit(data[i]);
      ones += data[i];
    end
    if (par_en) hold_bit(((ones % 2) ^ par_odd ^ bad_par) != 0);
    hold_bit(bad_stop != 1);
    if (two_stop) hold_bit(bad_stop != 2);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic rd();
    @(negedge clk) buf_ready = 1'b1;
    @(negedge clk) buf_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base, exp, mask;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 valid", buf_valid, 0);
    chk("R11 irq", rx_irq, 0);
    chk("R11 flags", {ovr_err, frame_err, par_err, err_sum}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R9 / R10 / R4 sweep over lengths, parity modes and stop counts
    for (int lc = 0; lc < 3; lc++)
      for (int pm = 0; pm < 3; pm++)
        for (int ts = 0; ts < 2; ts++)
          for (int v = 0; v < 2; v++) begin
            char_len = 2'(lc); par_en = (pm != 0); par_odd = (pm == 2);
            two_stop = ts[0];
            mask = (1 << len_of(char_len)) - 1;
            exp = ((v != 0) ? 'h1A5 : 'h05A) ^ (lc * 7 + pm * 3 + ts);
            exp = exp & mask;
            base = irq_cnt;
            send(exp, 0, 0);
            chk("R10 one irq", irq_cnt - base, 1);
            chk("R10 valid", buf_valid, 1);
            chk("R9 data", buf_data, exp);
            chk("R4 no parity error", par_err, 0);
            chk("R3 no framing error", frame_err, 0);
            rd();
            chk("R7 read empties", buf_valid, 0);
          end

    // R4 parity error, then R7/R5 read clears it
    char_len = 2'b01; par_en = 1; par_odd = 0; two_stop = 0;
    send('h3C, 1, 0);
    chk("R4 parity error", par_err, 1);
    chk("R5 sum on parity", err_sum, 1);
    chk("R4 data still delivered", buf_data, 'h3C);
    rd();
    chk("R7 read clears parity", par_err, 0);
    chk("R5 sum clears", err_sum, 0);
    par_odd = 1;
    send('h3D, 1, 0);
    chk("R4 odd parity error", par_err, 1);
    rd();

    // R3 framing error, second of two stop bits low
    par_en = 0; two_stop = 1;
    send('hA5, 0, 2);
    chk("R3 second stop low", frame_err, 1);
    chk("R5 sum on framing", err_sum, 1);
    // R6 mode 000 clears it
    @(negedge clk) mode_sel = 3'b000;
    @(negedge clk) mode_sel = 3'b001;
    @(negedge clk);
    chk("R6 mode clears framing", frame_err, 0);
    rd();
    two_stop = 0;
    send('h11, 0, 1);
    chk("R3 single stop low", frame_err, 1);
    rd();
    chk("R7 read clears framing", frame_err, 0);

    // R2 overrun: buffer unread while second frame arrives
    send('h55, 0, 0);
    base = irq_cnt;
    send('hAA, 0, 0);
    chk("R1 overrun flagged", ovr_err, 1);
    chk("R2 no irq on overrun", irq_cnt - base, 0);
    chk("R2 buffer kept", buf_data, 'h55);
    rd();
    chk("R7 read keeps overrun", ovr_err, 1);
    chk("R5 sum held by overrun", err_sum, 1);
    @(negedge clk) rx_en = 0;
    @(negedge clk) rx_en = 1;
    @(negedge clk);
    chk("R6 disable clears overrun", ovr_err, 0);
    chk("R5 sum clears after overrun", err_sum, 0);

    // R1 read during data bits avoids overrun
    send('h21, 0, 0);
    base = irq_cnt;
    fork
      send('h42, 0, 0);
      begin repeat (BIT_CLKS * 3) @(negedge clk); rd(); end
    join
    chk("R1 early read no overrun", ovr_err, 0);
    chk("R1 early read data", buf_data, 'h42);
    chk("R1 early read irq", irq_cnt - base, 1);

    // R1 read during second stop bit is too late
    two_stop = 1;
    base = irq_cnt;
    fork
      send('h99, 0, 0);
      begin repeat (BIT_CLKS * 10 + 8) @(negedge clk); rd(); end
    join
    chk("R1 late read overrun", ovr_err, 1);
    chk("R2 late read no irq", irq_cnt - base, 0);
    chk("R2 late read buffer empty", buf_valid, 0);
    @(negedge clk) rx_en = 0;
    @(negedge clk) rx_en = 1;
    two_stop = 0;

    // R8 noise glitch rejected
    base = irq_cnt;
    rx_line = 0;
    repeat (12) @(negedge clk);
    rx_line = 1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    chk("R8 glitch no irq", irq_cnt - base, 0);
    chk("R8 glitch no data", buf_valid, 0);
    send('h6B, 0, 0);
    chk("R8 frame after glitch", buf_data, 'h6B);
    rd();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule